// File: doc/BRIEF.md
# Processor Power-State Sequencer

This block decides which power mode a simple CPU core is in and when it may leave it. It tracks five modes: running, halted after a halt instruction, stop-granted while the system holds the stop-clock request, snooping while a bus snoop is handled out of a low-power mode, and sleeping. Its inputs are a halt-executed strobe, active-low requests for stop-clock, sleep, core reset, cache flush and bus init, a snoop-hit strobe with a matching snoop-done strobe, and four wake events: system-management interrupt, init, non-maskable interrupt and maskable interrupt.

Halt and stop-clock nest. When stop-clock is released, the core goes back to the mode it was in before the grant: halted or running. Wake events that arrive while the core cannot take them are stored, at most one per event kind. They are replayed as single service pulses once the core is running again. A clock-stop configuration bit, which resets to 1, decides whether the internal clock enable drops in the stop-granted and sleeping modes.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `pwr_state` reads 0 and `clk_en` is 1. No service pulse or acknowledge is active, and the clock-stop bit is 1. The state codes are 0 running, 1 halted, 2 stop-granted, 3 snooping and 4 sleeping.
- R2: A `halt_exec` strobe while running, with stop-clock released, makes `pwr_state` read 1 after the next clock edge.
- R3: While halted, any wake event on `wake_evt` moves the state to running at the next edge. Bit 0 is SMI, bit 1 is INIT, bit 2 is NMI and bit 3 is INTR. A stored pending event has the same effect. In the cycle the state first reads 0, `svc_pulse` carries the bits that caused the wake.
- R4: A low `flush_req_n` or `binit_req_n` while running or halted gives a one-cycle `flush_ack` or `binit_ack` at the next edge. The state does not change because of it, so a halted core stays halted.
- R5: A low `stop_req_n` while running or halted moves the state to 2. Raising it returns the state to whichever mode the grant was entered from.
- R6: While stop-granted, snooping or sleeping, flush and bus-init requests are dropped and give no acknowledge.
- R7: A low `core_rst_n` pulses `core_init` one cycle later and clears all pending events. If the state is 2 and stop-clock is held low, the state stays 2 and the later release goes to running. In any other case the state goes to 0 at the next edge.
- R8: A `snoop_hit` while stop-granted or halted moves the state to 3. A `snoop_done` while snooping returns the state to the mode the snoop left, at the next edge.
- R9: A low `sleep_req_n` while stop-granted moves the state to 4. Raising it while sleeping returns the state to 2.
- R10: Wake events seen while stop-granted, snooping or sleeping are each stored at most once. In the cycle the state first reads 0 again, they appear together as one single-cycle pulse on `svc_pulse`, and they are cleared in that same cycle. `svc_pulse` is never nonzero outside running.
- R11: `clk_en` is 0 exactly when the state is 2 or 4 and the clock-stop bit is 1. A `cfg_we` cycle loads `cfg_clk_stop` into that bit.
- R12: When several conditions hold in one cycle, these orders apply:
  - while running, stop-clock outranks halt;
  - while halted, stop-clock outranks a wake, which outranks a snoop;
  - while stop-granted, a stop-clock release outranks a snoop, which outranks sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| halt_exec | input | 1 | Strobe: core executed a halt instruction |
| stop_req_n | input | 1 | Active-low stop-clock request |
| sleep_req_n | input | 1 | Active-low sleep request |
| core_rst_n | input | 1 | Active-low core context reset |
| flush_req_n | input | 1 | Active-low cache flush request |
| binit_req_n | input | 1 | Active-low bus init request |
| snoop_hit | input | 1 | Strobe: bus snoop detected |
| snoop_done | input | 1 | Strobe: snoop handling finished |
| wake_evt | input | 4 | Wake events: SMI, INIT, NMI, INTR (bits 0..3) |
| cfg_we | input | 1 | Write strobe for the clock-stop bit |
| cfg_clk_stop | input | 1 | Value written to the clock-stop bit |
| pwr_state | output | 3 | Current power mode code |
| clk_en | output | 1 | Internal clock enable |
| svc_pulse | output | 4 | One-cycle service pulse per wake event |
| flush_ack | output | 1 | One-cycle flush service pulse |
| binit_ack | output | 1 | One-cycle bus-init service pulse |
| core_init | output | 1 | One-cycle context initialisation pulse |

## Verification
The hidden state here is the return target of a grant or snoop and the pending-event set. If the return target is wrong, nothing shows until the release, and then `pwr_state` settles in the wrong mode on that edge. A pending bit that is lost, doubled or kept too long shows only on the first cycle back in running, as a missing, repeated or extra `svc_pulse` bit. A halted core with a stale pending bit leaves halt one cycle after it entered. The bench therefore runs long grant, snoop and sleep dwells with events arriving during them. It compares every output on every cycle against an independent model, so a divergence is reported within one cycle of reaching a port.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int STATE_W = 3;
    localparam int NUM_EVT = 4;

    typedef enum logic [STATE_W-1:0] {
        PS_RUN   = 3'd0,
        PS_HALT  = 3'd1,
        PS_GRANT = 3'd2,
        PS_SNOOP = 3'd3,
        PS_SLEEP = 3'd4
    } pstate_e;

    // Control requests normalised to active-high
    typedef struct packed {
        logic halt_exec;
        logic stop;
        logic sleep;
        logic creset;
        logic snoop_hit;
        logic snoop_done;
    } ctl_req_t;

    // Bookkeeping for where a grant or snoop must return to
    typedef struct packed {
        logic grant_from_halt;
        logic snoop_from_halt;
    } ret_ctx_t;

    function automatic logic clocks_gateable(pstate_e s);
        return (s == PS_GRANT) || (s == PS_SLEEP);
    endfunction

    function automatic logic bus_serviceable(pstate_e s);
        return (s == PS_RUN) || (s == PS_HALT);
    endfunction

endpackage

// File: rtl/lpc_state_fsm.sv
module lpc_state_fsm
    import lpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_req_t req,
    input  logic     any_wake,
    output pstate_e  state,
    output logic     to_run,
    output logic     ctx_clear
);

    pstate_e  nxt;
    ret_ctx_t ctx_q, ctx_d;

    always_comb begin
        nxt   = state;
        ctx_d = ctx_q;
        if (req.creset) begin
            // Context reset: hold the grant only while stop-clock stays low
            nxt   = (state == PS_GRANT && req.stop) ? PS_GRANT : PS_RUN;
            ctx_d = '0;
        end else begin
            unique case (state)
                PS_RUN: begin
                    if (req.stop) begin
                        nxt                   = PS_GRANT;
                        ctx_d.grant_from_halt = 1'b0;
                    end else if (req.halt_exec) begin
                        nxt = PS_HALT;
                    end
                end
                PS_HALT: begin
                    if (req.stop) begin
                        nxt                   = PS_GRANT;
                        ctx_d.grant_from_halt = 1'b1;
                    end else if (any_wake) begin
                        nxt = PS_RUN;
                    end else if (req.snoop_hit) begin
                        nxt                   = PS_SNOOP;
                        ctx_d.snoop_from_halt = 1'b1;
                    end
                end
                PS_GRANT: begin
                    if (!req.stop) begin
                        nxt = ctx_q.grant_from_halt ? PS_HALT : PS_RUN;
                    end else if (req.snoop_hit) begin
                        nxt                   = PS_SNOOP;
                        ctx_d.snoop_from_halt = 1'b0;
                    end else if (req.sleep) begin
                        nxt = PS_SLEEP;
                    end
                end
                PS_SNOOP: begin
                    if (req.snoop_done) begin
                        nxt = ctx_q.snoop_from_halt ? PS_HALT : PS_GRANT;
                    end
                end
                PS_SLEEP: begin
                    if (!req.sleep) begin
                        nxt = PS_GRANT;
                    end
                end
                default: nxt = PS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_RUN;
            ctx_q <= '0;
        end else begin
            state <= nxt;
            ctx_q <= ctx_d;
        end
    end

    assign to_run    = (nxt == PS_RUN) && !req.creset;
    assign ctx_clear = req.creset;

endmodule

// File: rtl/lpc_evt_latch.sv
module lpc_evt_latch #(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic             to_run,
    input  logic             clear,
    output logic [EVT_W-1:0] pend,
    output logic [EVT_W-1:0] svc
);

    for (genvar g = 0; g < EVT_W; g++) begin : g_evt
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                pend[g] <= 1'b0;
                svc[g]  <= 1'b0;
            end else if (to_run) begin
                svc[g]  <= pend[g] | evt[g];
                pend[g] <= 1'b0;
            end else begin
                svc[g]  <= 1'b0;
                pend[g] <= pend[g] | evt[g];
            end
        end
    end

endmodule

// File: rtl/lpc_aux_unit.sv
module lpc_aux_unit
    import lpc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pstate_e state,
    input  logic    creset,
    input  logic    flush_req,
    input  logic    binit_req,
    input  logic    cfg_we,
    input  logic    cfg_val,
    output logic    flush_ack,
    output logic    binit_ack,
    output logic    core_init,
    output logic    clk_en
);

    logic stop_cfg;
    logic serviceable;

    assign serviceable = bus_serviceable(state) && !creset;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_ack <= 1'b0;
            binit_ack <= 1'b0;
            core_init <= 1'b0;
            stop_cfg  <= 1'b1;
        end else begin
            flush_ack <= serviceable && flush_req;
            binit_ack <= serviceable && binit_req;
            core_init <= creset;
            if (cfg_we) begin
                stop_cfg <= cfg_val;
            end
        end
    end

    assign clk_en = !(stop_cfg && clocks_gateable(state));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import lpc_pkg::*;
#(
    parameter int EVT_W = lpc_pkg::NUM_EVT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_exec,
    input  logic             stop_req_n,
    input  logic             sleep_req_n,
    input  logic             core_rst_n,
    input  logic             flush_req_n,
    input  logic             binit_req_n,
    input  logic             snoop_hit,
    input  logic             snoop_done,
    input  logic [EVT_W-1:0] wake_evt,
    input  logic             cfg_we,
    input  logic             cfg_clk_stop,
    output logic [2:0]       pwr_state,
    output logic             clk_en,
    output logic [EVT_W-1:0] svc_pulse,
    output logic             flush_ack,
    output logic             binit_ack,
    output logic             core_init
);

    ctl_req_t         req;
    pstate_e          state;
    logic             to_run;
    logic             ctx_clear;
    logic [EVT_W-1:0] pend;

    always_comb begin
        req.halt_exec  = halt_exec;
        req.stop       = !stop_req_n;
        req.sleep      = !sleep_req_n;
        req.creset     = !core_rst_n;
        req.snoop_hit  = snoop_hit;
        req.snoop_done = snoop_done;
    end

    lpc_state_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .any_wake  (|(wake_evt | pend)),
        .state     (state),
        .to_run    (to_run),
        .ctx_clear (ctx_clear)
    );

    lpc_evt_latch #(.EVT_W(EVT_W)) u_evt (
        .clk    (clk),
        .rst    (rst),
        .evt    (wake_evt),
        .to_run (to_run),
        .clear  (ctx_clear),
        .pend   (pend),
        .svc    (svc_pulse)
    );

    lpc_aux_unit u_aux (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .creset    (req.creset),
        .flush_req (!flush_req_n),
        .binit_req (!binit_req_n),
        .cfg_we    (cfg_we),
        .cfg_val   (cfg_clk_stop),
        .flush_ack (flush_ack),
        .binit_ack (binit_ack),
        .core_init (core_init),
        .clk_en    (clk_en)
    );

    assign pwr_state = state;

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
    parameter int EVT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             halt_exec,
    input logic             stop_req_n,
    input logic             sleep_req_n,
    input logic             core_rst_n,
    input logic             snoop_hit,
    input logic             snoop_done,
    input logic [2:0]       pwr_state,
    input logic [EVT_W-1:0] svc_pulse,
    input logic             flush_ack,
    input logic             binit_ack
);

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
        pwr_state <= 3'd4);

    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd0 && stop_req_n && halt_exec && core_rst_n) |=> pwr_state == 3'd1);

    assert_stop_entry_R5: assert property (@(posedge clk) disable iff (rst)
        ((pwr_state == 3'd0 || pwr_state == 3'd1) && !stop_req_n && core_rst_n) |=> pwr_state == 3'd2);

    assert_no_bus_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (pwr_state >= 3'd2) |=> (!flush_ack && !binit_ack));

    assert_reset_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd2 && !stop_req_n && !core_rst_n) |=> (pwr_state == 3'd2 && svc_pulse == '0));

    assert_snoop_return_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd3 && snoop_done && core_rst_n) |=> (pwr_state == 3'd1 || pwr_state == 3'd2));

    assert_snoop_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd2 && !stop_req_n && snoop_hit && core_rst_n) |=> pwr_state == 3'd3);

    assert_sleep_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd4 && sleep_req_n && core_rst_n) |=> pwr_state == 3'd2);

    assert_svc_only_run_R10: assert property (@(posedge clk) disable iff (rst)
        (svc_pulse != '0) |-> pwr_state == 3'd0);

    assert_svc_single_R10: assert property (@(posedge clk) disable iff (rst)
        (svc_pulse != '0) |=> svc_pulse == '0 || $past(pwr_state) == 3'd0 && pwr_state == 3'd0);

    assert_grant_release_R12: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd2 && stop_req_n && core_rst_n) |=> (pwr_state == 3'd0 || pwr_state == 3'd1));

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.EVT_W(EVT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .halt_exec   (halt_exec),
    .stop_req_n  (stop_req_n),
    .sleep_req_n (sleep_req_n),
    .core_rst_n  (core_rst_n),
    .snoop_hit   (snoop_hit),
    .snoop_done  (snoop_done),
    .pwr_state   (pwr_state),
    .svc_pulse   (svc_pulse),
    .flush_ack   (flush_ack),
    .binit_ack   (binit_ack)
);

// File: tb/pwr_state_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_state_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_exec = 1'b0;
    logic       stop_req_n = 1'b1;
    logic       sleep_req_n = 1'b1;
    logic       core_rst_n = 1'b1;
    logic       flush_req_n = 1'b1;
    logic       binit_req_n = 1'b1;
    logic       snoop_hit = 1'b0;
    logic       snoop_done = 1'b0;
    logic [3:0] wake_evt = 4'd0;
    logic       cfg_we = 1'b0;
    logic       cfg_clk_stop = 1'b1;
    logic [2:0] pwr_state;
    logic       clk_en;
    logic [3:0] svc_pulse;
    logic       flush_ack;
    logic       binit_ack;
    logic       core_init;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_state_ctrl u_pwr_state_ctrl (
        .clk(clk), .rst(rst), .halt_exec(halt_exec), .stop_req_n(stop_req_n),
        .sleep_req_n(sleep_req_n), .core_rst_n(core_rst_n), .flush_req_n(flush_req_n),
        .binit_req_n(binit_req_n), .snoop_hit(snoop_hit), .snoop_done(snoop_done),
        .wake_evt(wake_evt), .cfg_we(cfg_we), .cfg_clk_stop(cfg_clk_stop),
        .pwr_state(pwr_state), .clk_en(clk_en), .svc_pulse(svc_pulse),
        .flush_ack(flush_ack), .binit_ack(binit_ack), .core_init(core_init)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_state, m_pend, m_svc, m_fack, m_back, m_init, m_cfg;
    bit m_grant_halt, m_snoop_halt;
    int ns, wake_all;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_pend = 0; m_svc = 0; m_fack = 0; m_back = 0;
            m_init = 0; m_cfg = 1; m_grant_halt = 0; m_snoop_halt = 0;
        end else begin
            wake_all = m_pend | int'(wake_evt);
            m_init = (core_rst_n == 1'b0) ? 1 : 0;
            m_fack = (core_rst_n && m_state < 2 && !flush_req_n) ? 1 : 0;
            m_back = (core_rst_n && m_state < 2 && !binit_req_n) ? 1 : 0;
            if (cfg_we) m_cfg = cfg_clk_stop ? 1 : 0;
            ns = m_state;
            if (!core_rst_n) begin
                ns = (m_state == 2 && !stop_req_n) ? 2 : 0;
                m_grant_halt = 0; m_snoop_halt = 0;
                m_pend = 0; m_svc = 0;
            end else begin
                if (m_state == 0) begin
                    if (!stop_req_n) begin ns = 2; m_grant_halt = 0; end
                    else if (halt_exec) ns = 1;
                end else if (m_state == 1) begin
                    if (!stop_req_n) begin ns = 2; m_grant_halt = 1; end
                    else if (wake_all != 0) ns = 0;
                    else if (snoop_hit) begin ns = 3; m_snoop_halt = 1; end
                end else if (m_state == 2) begin
                    if (stop_req_n) ns = m_grant_halt ? 1 : 0;
                    else if (snoop_hit) begin ns = 3; m_snoop_halt = 0; end
                    else if (!sleep_req_n) ns = 4;
                end else if (m_state == 3) begin
                    if (snoop_done) ns = m_snoop_halt ? 1 : 2;
                end else begin
                    if (sleep_req_n) ns = 2;
                end
                if (ns == 0) begin m_svc = wake_all; m_pend = 0; end
                else begin m_svc = 0; m_pend = wake_all; end
            end
            m_state = ns;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R12 pwr_state", int'(pwr_state), m_state);
            chk("R10 svc_pulse", int'(svc_pulse), m_svc);
            chk("R11 clk_en", int'(clk_en), (m_cfg == 1 && (m_state == 2 || m_state == 4)) ? 0 : 1);
            chk("R4 flush_ack", int'(flush_ack), m_fack);
            chk("R6 binit_ack", int'(binit_ack), m_back);
            chk("R7 core_init", int'(core_init), m_init);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [3:0] v);
        wake_evt = v; tick(); wake_evt = 4'd0;
    endtask

    // ---------------- directed and random scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        at_neg();
        chk("R1 state after reset", int'(pwr_state), 0);
        chk("R1 clk_en after reset", int'(clk_en), 1);
        chk("R1 svc after reset", int'(svc_pulse), 0);

        // R2 halt entry
        tick(); halt_exec = 1'b1; tick(); halt_exec = 1'b0;
        at_neg(); chk("R2 halt entry", int'(pwr_state), 1);

        // R4 flush in halt
        tick(); flush_req_n = 1'b0; tick(); flush_req_n = 1'b1;
        at_neg(); chk("R4 flush ack in halt", int'(flush_ack), 1);
        chk("R4 stays halted", int'(pwr_state), 1);

        // R3 wake from halt by INTR
        tick(); pulse_evt(4'b1000);
        at_neg(); chk("R3 wake state", int'(pwr_state), 0);
        chk("R3 wake pulse", int'(svc_pulse), 8);
        at_neg(); chk("R3 pulse single", int'(svc_pulse), 0);

        // R4 bus init in run
        tick(); binit_req_n = 1'b0; tick(); binit_req_n = 1'b1;
        at_neg(); chk("R4 binit ack in run", int'(binit_ack), 1);

        // R5 and R10: grant from run, events latched, replay once
        tick(); stop_req_n = 1'b0; tick();
        at_neg(); chk("R5 grant entry", int'(pwr_state), 2);
        chk("R11 clock gated", int'(clk_en), 0);
        tick(); flush_req_n = 1'b0; tick(); flush_req_n = 1'b1;
        at_neg(); chk("R6 flush ignored", int'(flush_ack), 0);
        tick(); pulse_evt(4'b0001); pulse_evt(4'b0001); pulse_evt(4'b0100);
        at_neg(); chk("R10 no pulse in grant", int'(svc_pulse), 0);
        tick(); stop_req_n = 1'b1; tick();
        at_neg(); chk("R5 return to run", int'(pwr_state), 0);
        chk("R10 replay pulse", int'(svc_pulse), 5);
        at_neg(); chk("R10 replay once", int'(svc_pulse), 0);

        // R5 nesting: halt -> grant -> halt, pending wakes it
        tick(); halt_exec = 1'b1; tick(); halt_exec = 1'b0;
        stop_req_n = 1'b0; tick();
        pulse_evt(4'b0010);
        stop_req_n = 1'b1; tick();
        at_neg(); chk("R5 return to halt", int'(pwr_state), 1);
        at_neg(); chk("R3 pending wakes halt", int'(pwr_state), 0);
        chk("R10 pending replay", int'(svc_pulse), 2);

        // R8 / R9 snoop and sleep out of grant
        tick(); stop_req_n = 1'b0; tick();
        snoop_hit = 1'b1; tick(); snoop_hit = 1'b0;
        at_neg(); chk("R8 snoop entry", int'(pwr_state), 3);
        tick(); snoop_done = 1'b1; tick(); snoop_done = 1'b0;
        at_neg(); chk("R8 snoop return grant", int'(pwr_state), 2);
        tick(); sleep_req_n = 1'b0; tick();
        at_neg(); chk("R9 sleep entry", int'(pwr_state), 4);
        chk("R11 gated in sleep", int'(clk_en), 0);
        tick(); binit_req_n = 1'b0; tick(); binit_req_n = 1'b1;
        at_neg(); chk("R6 binit ignored", int'(binit_ack), 0);
        tick(); sleep_req_n = 1'b1; tick();
        at_neg(); chk("R9 sleep exit", int'(pwr_state), 2);
        // R12: release with snoop in the same cycle -> run
        tick(); stop_req_n = 1'b1; snoop_hit = 1'b1; tick(); snoop_hit = 1'b0;
        at_neg(); chk("R12 release beats snoop", int'(pwr_state), 0);
        // R12: stop beats halt in run
        tick(); stop_req_n = 1'b0; halt_exec = 1'b1; tick(); halt_exec = 1'b0;
        at_neg(); chk("R12 stop beats halt", int'(pwr_state), 2);

        // R7 core reset held in grant
        tick(); pulse_evt(4'b0001);
        core_rst_n = 1'b0; tick(); core_rst_n = 1'b1;
        at_neg(); chk("R7 grant kept", int'(pwr_state), 2);
        chk("R7 init pulse", int'(core_init), 1);
        tick(); stop_req_n = 1'b1; tick();
        at_neg(); chk("R7 release to run", int'(pwr_state), 0);
        chk("R7 pending cleared", int'(svc_pulse), 0);
        tick(); halt_exec = 1'b1; tick(); halt_exec = 1'b0;
        core_rst_n = 1'b0; tick(); core_rst_n = 1'b1;
        at_neg(); chk("R7 halt reset to run", int'(pwr_state), 0);

        // R11 clock-stop bit cleared
        tick(); cfg_we = 1'b1; cfg_clk_stop = 1'b0; tick(); cfg_we = 1'b0;
        stop_req_n = 1'b0; tick();
        at_neg(); chk("R11 not gated with bit 0", int'(clk_en), 1);
        tick(); cfg_we = 1'b1; cfg_clk_stop = 1'b1; tick(); cfg_we = 1'b0;
        at_neg(); chk("R11 gated with bit 1", int'(clk_en), 0);
        tick(); stop_req_n = 1'b1; tick();

        // R8 snoop out of halt
        tick(); halt_exec = 1'b1; tick(); halt_exec = 1'b0;
        snoop_hit = 1'b1; tick(); snoop_hit = 1'b0;
        at_neg(); chk("R8 snoop from halt", int'(pwr_state), 3);
        tick(); snoop_done = 1'b1; tick(); snoop_done = 1'b0;
        at_neg(); chk("R8 back to halt", int'(pwr_state), 1);
        tick(); pulse_evt(4'b0100);

        // random traffic, checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if ($urandom_range(0, 15) == 0) stop_req_n = ~stop_req_n;
            if ($urandom_range(0, 11) == 0) sleep_req_n = ~sleep_req_n;
            halt_exec   = ($urandom_range(0, 7) == 0);
            core_rst_n  = ($urandom_range(0, 63) != 0);
            flush_req_n = ($urandom_range(0, 5) != 0);
            binit_req_n = ($urandom_range(0, 5) != 0);
            snoop_hit   = ($urandom_range(0, 9) == 0);
            snoop_done  = ($urandom_range(0, 3) == 0);
            wake_evt    = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            cfg_we      = ($urandom_range(0, 99) == 0);
            cfg_clk_stop = 1'($urandom_range(0, 1));
        end
        @(posedge clk); #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got 1 expected 0 (run hung)");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule